// File: doc/BRIEF.md
# Synthetic Mesh Traffic Injector

This block sits at one node of a square two-dimensional mesh network-on-chip and produces test traffic for it. In every cycle it takes a pseudo-random draw and compares it with a programmable rate to decide whether to create a packet. The destination node comes from one of four spatial patterns: uniform random, tornado, bit complement, or the node itself. The destination id is shifted into an address field. The message class is read, instruction-fetch read or write, chosen with equal weight, and the class number also names the virtual network the packet travels on.

Packets leave on a valid/ready request port. If the network refuses a packet, the block keeps it and offers it again, and it creates no new packet until that one is taken. Responses arrive on a separate one-bit port. Their only use is to reset a no-response watchdog, which raises a sticky deadlock flag once a configured number of quiet cycles has passed. Two limits stop injection. A packet budget applies when fixed-count mode is on. A run-length limit sets a sticky done flag after a configured number of cycles.

Top module: `mtg_traffic_gen`

## Requirements
- R1: During and right after synchronous reset, `req_valid`, `req_addr`, `req_class`, `pkt_count`, `done` and `deadlock` are all zero.
- R2: The random source is a 32-bit Galois LFSR. It shifts right, and when the bit shifted out is 1 it XORs the mask 0x80200003 into the result. It loads the nonzero parameter SEED at reset and steps once on every clock after that. On an edge where the state S gives (S mod 10^PRECISION) < `cfg_rate`, and the other conditions allow it, a packet is created and becomes visible one cycle later. A rate of 0 never injects, and a rate of 10^PRECISION or more injects whenever the other conditions allow.
- R3: The class of a created packet is S[23:16] mod 3. Class 0 is a read, 1 is an instruction-fetch read and 2 is a write. The class is driven on `req_class` and doubles as the virtual network number, so `req_class` never shows 3 while `req_valid` is high.
- R4: `cfg_pattern` = 0 (uniform) chooses destination S[24 +: ID_W], which is a random value modulo the node count K*K.
- R5: `cfg_pattern` = 1 (tornado) uses x = id mod K and y = id / K. It keeps y and sets dest_x = (x + K/2 - 1) mod K, with integer halving. The destination is dest_y*K + dest_x.
- R6: `cfg_pattern` = 2 (bit complement) sets dest_x = K-1-x and dest_y = K-1-y.
- R7: `cfg_pattern` = 3 sends to the node's own id.
- R8: `req_addr` equals the destination id shifted left by OFFSET_BITS, so its low OFFSET_BITS bits are zero.
- R9: A packet offered while `req_ready` is low stays on the port with the same address and class. No new packet is created while it waits. A packet is created on an edge only when the slot is free (`req_valid` low or `req_ready` high). An accepted packet with no new one behind it drops `req_valid`.
- R10: `pkt_count` counts packets at creation, which is their first offer, whether or not that offer is accepted.
- R11: While `cfg_fixed_mode` is high, no packet is created once `pkt_count` has reached `cfg_max_pkts`. While it is low there is no count limit.
- R12: `done` rises at the edge on which the number of clocks since reset reaches `cfg_run_cycles`. It then stays high until reset, and no packet is created while it is high.
- R13: A quiet counter clears on every edge with `rsp_valid` high and otherwise counts up, saturating at WDOG_LIMIT. `deadlock` rises on the edge on which the counter reaches WDOG_LIMIT and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | ID_W (4) | Id of this node in the mesh |
| cfg_pattern | input | 2 | Destination pattern: 0 uniform, 1 tornado, 2 complement, 3 self |
| cfg_rate | input | RATE_W (10) | Injection threshold, out of 10^PRECISION |
| cfg_fixed_mode | input | 1 | Enables the packet budget |
| cfg_max_pkts | input | CNT_W (16) | Packet budget |
| cfg_run_cycles | input | CYC_W (32) | Run length in cycles |
| req_valid | output | 1 | Packet on offer |
| req_ready | input | 1 | Network accepts the packet on offer |
| req_addr | output | ADDR_W (32) | Destination id shifted by OFFSET_BITS |
| req_class | output | 2 | Message class and virtual network |
| rsp_valid | input | 1 | A response arrived this cycle |
| pkt_count | output | CNT_W (16) | Packets created since reset |
| done | output | 1 | Run length reached |
| deadlock | output | 1 | No response for WDOG_LIMIT cycles |

## Verification
Uniform traffic at a mid rate with random ready and response pulses checks the gate threshold, the class draw and the uniform field together on every cycle. An error in the LFSR mask, the modulus or the field position shows up as a mismatch against the model within a few cycles. Tornado, complement and self destinations are each run from one chosen node id at full rate, so each shows a fixed, known address that separates the three coordinate transforms. Constant refusal, a small budget, a short run limit, a zero rate, and response pulses that stop partway through separate holding from regenerating, counting at offer from counting at accept, and each stop condition from the others.

// File: rtl/mtg_pkg.sv
`timescale 1ns/1ps
package mtg_pkg;

  typedef enum logic [1:0] {
    PAT_UNIFORM    = 2'd0,
    PAT_TORNADO    = 2'd1,
    PAT_COMPLEMENT = 2'd2,
    PAT_SELF       = 2'd3
  } pattern_e;

  typedef enum logic [1:0] {
    CLS_READ   = 2'd0,
    CLS_IFETCH = 2'd1,
    CLS_WRITE  = 2'd2,
    CLS_RSVD   = 2'd3
  } msg_class_e;

  localparam int unsigned RAND_W = 32;
  localparam logic [RAND_W-1:0] LFSR_MASK = 32'h8020_0003;

  // one Galois step, shifting toward bit 0
  function automatic logic [RAND_W-1:0] lfsr_next(input logic [RAND_W-1:0] s);
    lfsr_next = (s >> 1) ^ (s[0] ? LFSR_MASK : '0);
  endfunction

endpackage

// File: rtl/mtg_lfsr.sv
`timescale 1ns/1ps
module mtg_lfsr
  import mtg_pkg::*;
#(
  parameter logic [RAND_W-1:0] SEED = 32'h1ACE_B00C
) (
  input  logic              clk,
  input  logic              rst,
  output logic [RAND_W-1:0] state
);

  logic [RAND_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= lfsr_next(state_q);
  end

  assign state = state_q;

endmodule

// File: rtl/mtg_dest_calc.sv
`timescale 1ns/1ps
module mtg_dest_calc
  import mtg_pkg::*;
#(
  parameter int unsigned MESH_K = 4,
  localparam int unsigned AX_W  = $clog2(MESH_K),
  localparam int unsigned ID_W  = 2 * AX_W
) (
  input  logic [ID_W-1:0] node_id,
  input  pattern_e        pattern,
  input  logic [ID_W-1:0] rand_bits,
  output logic [ID_W-1:0] dest_id
);

  localparam logic [AX_W-1:0] TORNADO_STEP = AX_W'(MESH_K / 2 - 1);

  logic [AX_W-1:0] my_x, my_y;
  logic [AX_W-1:0] tor_x, cmp_x, cmp_y;

  // K is a power of two: mod and div reduce to bit slices
  assign my_x = node_id[AX_W-1:0];
  assign my_y = node_id[ID_W-1:AX_W];

  // additions wrap at K for free
  assign tor_x = my_x + TORNADO_STEP;
  assign cmp_x = ~my_x;
  assign cmp_y = ~my_y;

  always_comb begin
    unique case (pattern)
      PAT_UNIFORM:    dest_id = rand_bits;
      PAT_TORNADO:    dest_id = {my_y, tor_x};
      PAT_COMPLEMENT: dest_id = {cmp_y, cmp_x};
      default:        dest_id = node_id;
    endcase
  end

endmodule

// File: rtl/mtg_inject_gate.sv
`timescale 1ns/1ps
module mtg_inject_gate
  import mtg_pkg::*;
#(
  parameter int unsigned RANGE  = 1000,
  parameter int unsigned RATE_W = 10,
  parameter int unsigned CNT_W  = 16
) (
  input  logic [RAND_W-1:0] rand_state,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              cfg_fixed_mode,
  input  logic [CNT_W-1:0]  cfg_max_pkts,
  input  logic [CNT_W-1:0]  sent_cnt,
  input  logic              run_done,
  input  logic              slot_free,
  output logic              fire,
  output msg_class_e        pkt_class
);

  logic [RAND_W-1:0] gate_val;
  logic              rate_hit;
  logic              budget_ok;
  logic [7:0]        cls_raw;

  assign gate_val  = rand_state % RAND_W'(RANGE);
  assign rate_hit  = gate_val < RAND_W'(cfg_rate);
  assign budget_ok = !cfg_fixed_mode || (sent_cnt < cfg_max_pkts);
  assign fire      = rate_hit && budget_ok && slot_free && !run_done;

  assign cls_raw   = rand_state[23:16];
  assign pkt_class = msg_class_e'(2'(cls_raw % 8'd3));

endmodule

// File: rtl/mtg_timers.sv
`timescale 1ns/1ps
module mtg_timers #(
  parameter int unsigned CYC_W      = 32,
  parameter int unsigned WDOG_LIMIT = 500000,
  localparam int unsigned IDLE_W    = $clog2(WDOG_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rsp_valid,
  input  logic [CYC_W-1:0] run_cycles,
  output logic             done,
  output logic             deadlock
);

  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(WDOG_LIMIT);

  logic [CYC_W-1:0]  cyc_q, cyc_inc;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic              done_q, dl_q;

  assign cyc_inc = (&cyc_q) ? cyc_q : cyc_q + 1'b1;

  always_comb begin
    if (rsp_valid)              idle_d = '0;
    else if (idle_q == IDLE_MAX) idle_d = idle_q;
    else                        idle_d = idle_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= '0;
      done_q <= 1'b0;
      idle_q <= '0;
      dl_q   <= 1'b0;
    end else begin
      cyc_q  <= cyc_inc;
      done_q <= done_q | (cyc_inc >= run_cycles);
      idle_q <= idle_d;
      dl_q   <= dl_q | (idle_d == IDLE_MAX);
    end
  end

  assign done     = done_q;
  assign deadlock = dl_q;

endmodule

// File: rtl/mtg_traffic_gen.sv
`timescale 1ns/1ps
module mtg_traffic_gen
  import mtg_pkg::*;
#(
  parameter int unsigned MESH_K      = 4,
  parameter int unsigned PRECISION   = 3,
  parameter int unsigned OFFSET_BITS = 6,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned CYC_W       = 32,
  parameter int unsigned WDOG_LIMIT  = 500000,
  parameter logic [31:0] SEED        = 32'h1ACE_B00C,
  localparam int unsigned AX_W       = $clog2(MESH_K),
  localparam int unsigned ID_W       = 2 * AX_W,
  localparam int unsigned RANGE      = 10 ** PRECISION,
  localparam int unsigned RATE_W     = $clog2(RANGE + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   node_id,
  input  logic [1:0]        cfg_pattern,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              cfg_fixed_mode,
  input  logic [CNT_W-1:0]  cfg_max_pkts,
  input  logic [CYC_W-1:0]  cfg_run_cycles,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        req_class,
  input  logic              rsp_valid,
  output logic [CNT_W-1:0]  pkt_count,
  output logic              done,
  output logic              deadlock
);

  logic [RAND_W-1:0] rnd;
  logic [ID_W-1:0]   dest_id;
  logic              fire, slot_free;
  msg_class_e        new_class;

  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;
  msg_class_e        cls_q;
  logic [CNT_W-1:0]  cnt_q;

  mtg_lfsr #(.SEED(SEED)) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .state (rnd)
  );

  mtg_dest_calc #(.MESH_K(MESH_K)) u_dest (
    .node_id   (node_id),
    .pattern   (pattern_e'(cfg_pattern)),
    .rand_bits (rnd[24 +: ID_W]),
    .dest_id   (dest_id)
  );

  assign slot_free = !vld_q || req_ready;

  mtg_inject_gate #(.RANGE(RANGE), .RATE_W(RATE_W), .CNT_W(CNT_W)) u_gate (
    .rand_state     (rnd),
    .cfg_rate       (cfg_rate),
    .cfg_fixed_mode (cfg_fixed_mode),
    .cfg_max_pkts   (cfg_max_pkts),
    .sent_cnt       (cnt_q),
    .run_done       (done),
    .slot_free      (slot_free),
    .fire           (fire),
    .pkt_class      (new_class)
  );

  mtg_timers #(.CYC_W(CYC_W), .WDOG_LIMIT(WDOG_LIMIT)) u_timers (
    .clk        (clk),
    .rst        (rst),
    .rsp_valid  (rsp_valid),
    .run_cycles (cfg_run_cycles),
    .done       (done),
    .deadlock   (deadlock)
  );

  // single-entry output register doubles as the retry holding slot
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      cls_q  <= CLS_READ;
      cnt_q  <= '0;
    end else if (fire) begin
      vld_q  <= 1'b1;
      addr_q <= ADDR_W'(dest_id) << OFFSET_BITS;
      cls_q  <= new_class;
      cnt_q  <= cnt_q + 1'b1;
    end else if (req_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign req_valid = vld_q;
  assign req_addr  = addr_q;
  assign req_class = cls_q;
  assign pkt_count = cnt_q;

endmodule

// File: rtl/mtg_traffic_gen_checker.sv
`timescale 1ns/1ps
module mtg_traffic_gen_checker #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned OFFSET_BITS = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_class,
  input logic              cfg_fixed_mode,
  input logic [CNT_W-1:0]  cfg_max_pkts,
  input logic [CNT_W-1:0]  pkt_count,
  input logic              done,
  input logic              deadlock
);

  localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << OFFSET_BITS) - 1'b1;

  AST_HOLD_REFUSED: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_class)); // R9

  AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_class != 2'd3); // R3

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_addr & LOW_MASK) == '0); // R8

  AST_COUNT_AT_OFFER: assert property (@(posedge clk) disable iff (rst)
    pkt_count != $past(pkt_count) |-> req_valid); // R10

  AST_BUDGET_FROZEN: assert property (@(posedge clk) disable iff (rst)
    cfg_fixed_mode && pkt_count >= cfg_max_pkts |=> $stable(pkt_count)); // R11

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R12

  AST_DONE_NO_INJECT: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(pkt_count)); // R12

  AST_DEADLOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    deadlock |=> deadlock); // R13

endmodule

bind mtg_traffic_gen mtg_traffic_gen_checker #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFFSET_BITS(OFFSET_BITS)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_addr       (req_addr),
  .req_class      (req_class),
  .cfg_fixed_mode (cfg_fixed_mode),
  .cfg_max_pkts   (cfg_max_pkts),
  .pkt_count      (pkt_count),
  .done           (done),
  .deadlock       (deadlock)
);

// File: tb/mtg_traffic_gen_test.sv
`timescale 1ns/1ps
module mtg_traffic_gen_test;

  localparam int K     = 4;
  localparam int OFF   = 6;
  localparam int RANGE = 1000;
  localparam int WDOG  = 200;
  localparam int SEEDV = 32'h1ACE_B00C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  node_id = '0;
  logic [1:0]  cfg_pattern = '0;
  logic [9:0]  cfg_rate = '0;
  logic        cfg_fixed_mode = 1'b0;
  logic [15:0] cfg_max_pkts = '0;
  logic [31:0] cfg_run_cycles = 32'hFFFF_FFFF;
  logic        req_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [1:0]  req_class;
  logic [15:0] pkt_count;
  logic        done, deadlock;

  int checks = 0;
  int errors = 0;
  int ready_mode = 1;  // 0 low, 1 high, 2 random
  int rsp_period = 0;  // 0 none, -1 random, else period
  int tick = 0;

  always #5 clk = ~clk;

  mtg_traffic_gen #(.WDOG_LIMIT(WDOG)) uut (
    .clk(clk), .rst(rst), .node_id(node_id), .cfg_pattern(cfg_pattern),
    .cfg_rate(cfg_rate), .cfg_fixed_mode(cfg_fixed_mode), .cfg_max_pkts(cfg_max_pkts),
    .cfg_run_cycles(cfg_run_cycles), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_class(req_class), .rsp_valid(rsp_valid),
    .pkt_count(pkt_count), .done(done), .deadlock(deadlock)
  );

  // ---------------- behavioural reference model ----------------
  int unsigned m_lfsr = SEEDV;
  bit          m_valid = 0;
  int unsigned m_addr = 0;
  int          m_class = 0;
  int          m_cnt = 0;
  longint      m_cyc = 0;
  bit          m_done = 0;
  int          m_idle = 0;
  bit          m_dl = 0;
  bit          seen_edge = 0;

  function automatic int pick_dest(int unsigned s, int pat, int id);
    int x, y, dx, dy;
    x = id % K; y = id / K;
    case (pat)
      0: return int'((s >> 24) % (K * K));
      1: begin dx = (x + K / 2 - 1) % K; return y * K + dx; end
      2: begin dx = K - 1 - x; dy = K - 1 - y; return dy * K + dx; end
      default: return id;
    endcase
  endfunction

  always @(posedge clk) begin
    bit fire;
    seen_edge <= 1'b1;
    if (rst) begin
      m_lfsr = SEEDV; m_valid = 0; m_addr = 0; m_class = 0; m_cnt = 0;
      m_cyc = 0; m_done = 0; m_idle = 0; m_dl = 0;
    end else begin
      fire = !m_done && (!m_valid || req_ready) && ((m_lfsr % RANGE) < cfg_rate)
             && (!cfg_fixed_mode || m_cnt < cfg_max_pkts);
      if (fire) begin
        m_valid = 1;
        m_addr  = pick_dest(m_lfsr, cfg_pattern, node_id) << OFF;
        m_class = int'(((m_lfsr >> 16) & 255) % 3);
        m_cnt   = m_cnt + 1;
      end else if (req_ready) m_valid = 0;
      m_cyc = m_cyc + 1;
      if (m_cyc >= cfg_run_cycles) m_done = 1;
      if (rsp_valid) m_idle = 0;
      else if (m_idle < WDOG) m_idle = m_idle + 1;
      if (m_idle == WDOG) m_dl = 1;
      m_lfsr = (m_lfsr >> 1) ^ ((m_lfsr & 1) != 0 ? 32'h8020_0003 : 32'h0);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (seen_edge) begin
      chk(req_valid == m_valid, "R2/R9 req_valid", 32'(req_valid), 32'(m_valid));
      chk(req_addr == m_addr, "R4-R8 addr (R4 R5 R6 R7 R8)", req_addr, m_addr);
      chk(req_class == 2'(m_class), "R3 class", 32'(req_class), 32'(m_class));
      chk(pkt_count == 16'(m_cnt), "R10 count", 32'(pkt_count), 32'(m_cnt));
      chk(done == m_done, "R12 done", 32'(done), 32'(m_done));
      chk(deadlock == m_dl, "R13 deadlock", 32'(deadlock), 32'(m_dl));
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (ready_mode)
        0: req_ready = 1'b0;
        1: req_ready = 1'b1;
        default: req_ready = 1'($urandom_range(0, 1));
      endcase
      if (rsp_period < 0)      rsp_valid = ($urandom_range(0, 9) == 0);
      else if (rsp_period > 0) rsp_valid = (tick % rsp_period == 0);
      else                     rsp_valid = 1'b0;
      tick++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step(2);
    @(negedge clk);
    rst = 1'b0;
  endtask

  logic [31:0] held_addr;
  logic [15:0] held_cnt;

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset values
    chk(req_valid == 0, "R1 valid", 32'(req_valid), 0);
    chk(pkt_count == 0, "R1 count", 32'(pkt_count), 0);
    chk(done == 0 && deadlock == 0, "R1 flags", {30'd0, done, deadlock}, 0);
    chk(req_addr == 0, "R1 addr", req_addr, 0);

    // R2 R3 R4: uniform, mid rate, random ready and responses
    cfg_pattern = 0; cfg_rate = 400; node_id = 3; ready_mode = 2; rsp_period = -1;
    do_reset(); step(400);

    // R2: zero rate never injects
    cfg_rate = 0; ready_mode = 1; rsp_period = 10;
    do_reset(); step(100);
    chk(pkt_count == 0 && req_valid == 0, "R2 zero rate", 32'(pkt_count), 0);

    // R5 tornado from node 5 -> dest 6
    cfg_pattern = 1; cfg_rate = 10'(RANGE); node_id = 5;
    do_reset(); step(3);
    chk(req_valid && req_addr == 32'(6 << OFF), "R5 tornado addr", req_addr, 32'(6 << OFF));
    // R6 bit complement from node 1 -> dest 14
    cfg_pattern = 2; node_id = 1;
    do_reset(); step(3);
    chk(req_valid && req_addr == 32'(14 << OFF), "R6 complement addr", req_addr, 32'(14 << OFF));
    // R7 self from node 9
    cfg_pattern = 3; node_id = 9;
    do_reset(); step(3);
    chk(req_valid && req_addr == 32'(9 << OFF), "R7 self addr", req_addr, 32'(9 << OFF));

    // R9 R10: refusal holds the packet, count taken at first offer
    cfg_pattern = 0; ready_mode = 0;
    do_reset(); step(2);
    held_addr = req_addr; held_cnt = pkt_count;
    chk(held_cnt == 1, "R10 counted when refused", 32'(held_cnt), 1);
    step(10);
    chk(req_valid && req_addr == held_addr, "R9 held addr", req_addr, held_addr);
    chk(pkt_count == held_cnt, "R9 no regen while pending", 32'(pkt_count), 32'(held_cnt));
    ready_mode = 2; cfg_pattern = 1; step(150);

    // R11 fixed budget
    cfg_fixed_mode = 1; cfg_max_pkts = 5; ready_mode = 1; cfg_pattern = 0;
    do_reset(); step(40);
    chk(pkt_count == 5, "R11 budget", 32'(pkt_count), 5);
    cfg_fixed_mode = 0; step(5);
    chk(pkt_count > 5, "R11 unlimited when off", 32'(pkt_count), 6);

    // R12 run limit
    cfg_run_cycles = 50; cfg_rate = 300; ready_mode = 2;
    do_reset(); step(60);
    held_cnt = pkt_count;
    chk(done == 1, "R12 done set", 32'(done), 1);
    step(30);
    chk(pkt_count == held_cnt && done == 1, "R12 frozen", 32'(pkt_count), 32'(held_cnt));
    cfg_run_cycles = 32'hFFFF_FFFF;

    // R13 watchdog: pulses keep it quiet, silence trips it
    rsp_period = 50; cfg_pattern = 2;
    do_reset(); step(400);
    chk(deadlock == 0, "R13 fed watchdog", 32'(deadlock), 0);
    rsp_period = 0; step(WDOG + 10);
    chk(deadlock == 1, "R13 deadlock raised", 32'(deadlock), 1);
    rsp_period = 3; step(20);
    chk(deadlock == 1, "R13 sticky", 32'(deadlock), 1);

    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule